// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block turns the pending interrupt sources of a 16550-style serial port into the byte that software reads to identify an interrupt, plus a level, active-high interrupt line. Five source flags come in from the rest of the port: receive line error, receive data ready, character timeout, transmit holding empty and modem status change. The block holds the 4-bit enable register, and on every clock it picks the single highest-priority source that qualifies. It registers the result together with the FIFO-enable indication.

The owner of each source flag clears that flag when the block sends it an acknowledge pulse. A line-status read acknowledges the line error. A modem-status read acknowledges the modem change. A read of the identification byte acknowledges transmit-empty, but only while transmit-empty is the source being reported. In the cycle of the strobe, the block already leaves the acknowledged source out of the next evaluation, so the identification byte and the interrupt line move on after one clock edge. They do not wait for the owner to clear its flag.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the identification byte is 0x01, `irq` is 0 and the enable value `ier` is 0.
- R2: Bits 3:0 of the identification byte carry the code of the first qualifying source, in this order: line error 0x6, data ready 0x4, character timeout 0xC, transmit empty 0x2, modem change 0x0. When no source qualifies they read 0x1, so bit 0 is 0 exactly when an interrupt is pending.
- R3: Line error, data ready, transmit empty and modem change qualify only when `ier` bit 2, 0, 1 and 3 respectively is 1.
- R4: A pending character timeout qualifies whatever `ier` holds.
- R5: A write strobe stores only bits 3:0 of the write data in `ier`. The evaluation at that same clock edge already uses the new value, so `irq` can rise or fall one edge after the write.
- R6: Bits 7:6 of the identification byte are 11 while `fifo_en` is 1 and 00 otherwise. Bits 5:4 are always 0.
- R7: `lsr_rd` gives a same-cycle `ack_lerr` pulse and keeps the line error out of the evaluation at that edge. The next qualifying source is then reported, or 0x01 if there is none.
- R8: `msr_rd` gives a same-cycle `ack_msc` pulse and keeps the modem change out of the evaluation at that edge. If the modem change was reported, `irq` falls unless another source qualifies.
- R9: `iir_rd` gives an `ack_txe` pulse only while the reported code is 0x2, and then keeps transmit empty out of that evaluation. While any other code is reported, `iir_rd` changes nothing.
- R10: `irq` is a register equal to the inverse of identification bit 0. It changes at the first clock edge after a source or enable change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lerr | input | 1 | Receive line error pending |
| src_rxdat | input | 1 | Receive data ready pending |
| src_tmo | input | 1 | Character timeout pending |
| src_txe | input | 1 | Transmit holding empty pending |
| src_msc | input | 1 | Modem status change pending |
| fifo_en | input | 1 | FIFOs enabled |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| iir_rd | input | 1 | Identification byte read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| ier | output | 4 | Enable register value |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |
| ack_lerr | output | 1 | Clear pulse for the line error source |
| ack_txe | output | 1 | Clear pulse for the transmit empty source |
| ack_msc | output | 1 | Clear pulse for the modem change source |

## Verification
The properties take every strobe to be one cycle wide. They also take the owner of an acknowledged flag to drop it before the next clock edge, because the block masks that source for a single evaluation only. The bench follows this rule: it raises each strobe for one cycle and clears the matching source flag at the same falling edge where it drops the strobe. The bench changes source flags, `fifo_en` and the write data only on falling edges, so every evaluation sees settled inputs.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int DW = 8,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_lerr,
  input  logic          src_rxdat,
  input  logic          src_tmo,
  input  logic          src_txe,
  input  logic          src_msc,
  input  logic          fifo_en,
  input  logic          ier_wr,
  input  logic [DW-1:0] ier_wdata,
  input  logic          iir_rd,
  input  logic          lsr_rd,
  input  logic          msr_rd,
  output logic [EW-1:0] ier,
  output logic [DW-1:0] iir,
  output logic          irq,
  output logic          ack_lerr,
  output logic          ack_txe,
  output logic          ack_msc
);
  localparam logic [3:0] C_LERR = 4'h6;
  localparam logic [3:0] C_RXD  = 4'h4;
  localparam logic [3:0] C_TMO  = 4'hC;
  localparam logic [3:0] C_TXE  = 4'h2;
  localparam logic [3:0] C_MSC  = 4'h0;
  localparam logic [3:0] C_NONE = 4'h1;

  logic [EW-1:0] ier_q, en;
  logic [DW-1:0] id_q;
  logic          irq_q;
  logic [3:0]    code;

  assign en       = ier_wr ? ier_wdata[EW-1:0] : ier_q;
  assign ack_lerr = lsr_rd;
  assign ack_msc  = msr_rd;
  assign ack_txe  = iir_rd && (id_q[3:0] == C_TXE);

  always_comb begin
    if (src_lerr && en[2] && !lsr_rd)      code = C_LERR;
    else if (src_rxdat && en[0])           code = C_RXD;
    else if (src_tmo)                      code = C_TMO;
    else if (src_txe && en[1] && !ack_txe) code = C_TXE;
    else if (src_msc && en[3] && !msr_rd)  code = C_MSC;
    else                                   code = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      id_q  <= DW'(C_NONE);
      irq_q <= 1'b0;
    end else begin
      ier_q <= en;
      id_q  <= {{2{fifo_en}}, {(DW-6){1'b0}}, code};
      irq_q <= ~code[0];
    end
  end

  assign ier = ier_q;
  assign iir = id_q;
  assign irq = irq_q;

  p_irq_follows_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ~iir[0]);
  p_ier_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier == $past(ier_wdata[EW-1:0]));
  p_fifo_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |=> iir[7:4] == 4'b1100);
  p_tmo_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tmo && !ier_wr && !(src_lerr && ier_q[2] && !lsr_rd) && !(src_rxdat && ier_q[0]))
      |=> iir[3:0] == 4'hC);
  p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_wr && ier_q == '0 && !src_tmo) |=> (iir[3:0] == 4'h1 && !irq));
  p_lsr_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd |=> iir[3:0] != 4'h6);
  p_msr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msr_rd |=> iir[3:0] != 4'h0);
  p_txe_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_txe |=> iir[3:0] != 4'h2);
endmodule

// File: tb/uart_irq_prio_bench.sv
module uart_irq_prio_bench;
  logic clk = 0, rst_n = 0;
  logic src_lerr = 0, src_rxdat = 0, src_tmo = 0, src_txe = 0, src_msc = 0;
  logic fifo_en = 0, ier_wr = 0, iir_rd = 0, lsr_rd = 0, msr_rd = 0;
  logic [7:0] ier_wdata = 0;
  logic [3:0] ier;
  logic [7:0] iir;
  logic irq, ack_lerr, ack_txe, ack_msc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_prio u_uart_irq_prio (
    .clk(clk), .rst_n(rst_n), .src_lerr(src_lerr), .src_rxdat(src_rxdat),
    .src_tmo(src_tmo), .src_txe(src_txe), .src_msc(src_msc), .fifo_en(fifo_en),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
    .msr_rd(msr_rd), .ier(ier), .iir(iir), .irq(irq), .ack_lerr(ack_lerr),
    .ack_txe(ack_txe), .ack_msc(ack_msc));

  // {fifo_en, ier[3:0], lerr, rxdat, tmo, txe, msc, expected id}
  localparam logic [17:0] VEC [14] = '{
    {1'b0, 4'hF, 5'b11111, 8'h06},
    {1'b1, 4'hF, 5'b11111, 8'hC6},
    {1'b1, 4'hF, 5'b01111, 8'hC4},
    {1'b1, 4'hF, 5'b00111, 8'hCC},
    {1'b1, 4'hF, 5'b00011, 8'hC2},
    {1'b1, 4'hF, 5'b00001, 8'hC0},
    {1'b1, 4'hF, 5'b00000, 8'hC1},
    {1'b0, 4'h0, 5'b11011, 8'h01},
    {1'b0, 4'h0, 5'b00100, 8'h0C},
    {1'b0, 4'hB, 5'b11011, 8'h04},
    {1'b0, 4'h4, 5'b01011, 8'h01},
    {1'b0, 4'h8, 5'b00001, 8'h00},
    {1'b0, 4'h2, 5'b10010, 8'h02},
    {1'b1, 4'h1, 5'b11111, 8'hC4}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wdata = v; ier_wr = 1;
    @(negedge clk); ier_wr = 0;
  endtask

  task automatic srcs(input logic [4:0] s);
    {src_lerr, src_rxdat, src_tmo, src_txe, src_msc} = s;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 id", iir, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 ier", {4'b0, ier}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      fifo_en = VEC[i][17];
      srcs(VEC[i][12:8]);
      wr_ier({4'hA, VEC[i][16:13]});
      @(negedge clk);
      chk($sformatf("R2/R3/R4/R6 vec%0d id", i), iir, VEC[i][7:0]);
      chk($sformatf("R10 vec%0d irq", i), {7'b0, irq}, {7'b0, ~VEC[i][0]});
    end

    // R5: upper bits dropped, write drops irq at once
    fifo_en = 0; srcs(5'b00000);
    wr_ier(8'hFF);
    chk("R5 ier low bits", {4'b0, ier}, 8'h0F);
    wr_ier(8'h02); srcs(5'b00010);
    @(negedge clk);
    chk("R5 irq on", {7'b0, irq}, 8'h01);
    ier_wdata = 8'h00; ier_wr = 1;
    @(negedge clk); ier_wr = 0;
    chk("R5 irq off after one edge", {7'b0, irq}, 8'h00);
    chk("R5 id after disable", iir, 8'h01);

    // R10: latency of one edge
    srcs(5'b00000); wr_ier(8'h02); @(negedge clk);
    src_txe = 1; #1;
    chk("R10 irq before edge", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R10 irq after edge", {7'b0, irq}, 8'h01);

    // R7: line error acknowledged, next source shows
    srcs(5'b11000); wr_ier(8'h05); @(negedge clk);
    chk("R7 id before", iir, 8'h06);
    lsr_rd = 1; #1;
    chk("R7 ack_lerr", {7'b0, ack_lerr}, 8'h01);
    @(negedge clk); lsr_rd = 0; src_lerr = 0;
    chk("R7 id next", iir, 8'h04);
    srcs(5'b10000); @(negedge clk);
    lsr_rd = 1; @(negedge clk); lsr_rd = 0; src_lerr = 0;
    chk("R7 id none", iir, 8'h01);
    chk("R7 irq none", {7'b0, irq}, 8'h00);

    // R8: modem change acknowledged
    srcs(5'b00001); wr_ier(8'h08); @(negedge clk);
    chk("R8 id before", iir, 8'h00);
    msr_rd = 1; #1;
    chk("R8 ack_msc", {7'b0, ack_msc}, 8'h01);
    @(negedge clk); msr_rd = 0; src_msc = 0;
    chk("R8 irq off", {7'b0, irq}, 8'h00);
    chk("R8 id", iir, 8'h01);

    // R9: transmit empty acknowledged only when reported
    srcs(5'b01010); wr_ier(8'h03); @(negedge clk);
    chk("R9 id rx", iir, 8'h04);
    iir_rd = 1; #1;
    chk("R9 no ack", {7'b0, ack_txe}, 8'h00);
    @(negedge clk); iir_rd = 0;
    chk("R9 id unchanged", iir, 8'h04);
    src_rxdat = 0; @(negedge clk);
    chk("R9 id txe", iir, 8'h02);
    iir_rd = 1; #1;
    chk("R9 ack_txe", {7'b0, ack_txe}, 8'h01);
    @(negedge clk); iir_rd = 0; src_txe = 0;
    chk("R9 id cleared", iir, 8'h01);
    chk("R9 irq cleared", {7'b0, irq}, 8'h00);

    // R1: reset again in the middle of activity
    srcs(5'b00100); fifo_en = 1; @(negedge clk);
    rst_n = 0; #1;
    chk("R1 id on reset", iir, 8'h01);
    chk("R1 ier on reset", {4'b0, ier}, 8'h00);

    done = 1;
    summary();
    $finish;
  end
endmodule